// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block listens on a shared two-wire SMBus at the host's own slave address. It picks up the notification messages that peripheral devices send when they take the master role. A device starts a write to the host address and sends three payload bytes: first its own address, then a 16-bit status word, low byte first. The receiver pulls the data line low to acknowledge the address and each of the three payload bytes. When the stop condition closes a frame that is correct, it raises an interrupt.

The captured device byte and status word stay in output registers, together with the interrupt, until software pulses the clear input. A frame that ends too early or runs too long sets a sticky malformed flag and does not raise the interrupt. A correct frame that arrives while an earlier one is still pending sets an overrun flag and leaves the held values as they were. Both bus lines pass through a synchronizer and are edge-detected on the system clock, so the block needs no clock of its own.

Control is held in one state machine with these states. ST_IDLE waits for a start. ST_ADDR shifts in the address byte. ST_ACK_ARM waits for SCL to fall after a byte the block accepts. ST_ACK_DRIVE holds the data line low through the ninth clock. ST_DATA shifts in payload bytes. ST_OVER absorbs a payload byte beyond the third, without acknowledging it. ST_SKIP ignores a frame meant for someone else.

The transitions are as follows:
- A start moves any state to ST_ADDR.
- A stop moves any state to ST_IDLE.
- ST_ADDR goes to ST_ACK_ARM on a match and to ST_SKIP on a mismatch.
- ST_ACK_ARM goes to ST_ACK_DRIVE on an SCL fall.
- ST_ACK_DRIVE goes to ST_DATA on the next SCL fall.
- ST_DATA goes to ST_ACK_ARM after payload bytes one to three, and to ST_OVER after a fourth.

Top module: `hn_rx`

## Requirements
- R1: SCL and SDA are each synchronized through two flops. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. SDA transitions while SCL is low are data and never frame a transaction.
- R2: An address byte equal to {HOST_ADDR, 0} (seven address bits, then the write bit 0 in the LSB) is acknowledged. The block drives sda_pull_low high only while SCL is low and then through the ninth SCL clock.
- R3: An address byte with another address, or with the read bit 1, gets no acknowledge. The payload that follows gets none either, and irq, malformed and overrun are not affected.
- R4: After an accepted address, each of the first three payload bytes is acknowledged on its ninth clock.
- R5: After a correct frame, dev_addr holds the first payload byte and status_word holds {third byte, second byte}. The byte received second is the low half.
- R6: irq rises only after a stop that ends an accepted frame carrying exactly three payload bytes.
- R7: An accepted frame that is ended by a stop or a repeated start sets malformed instead of irq when it has fewer than three payload bytes. The same applies when it has more than three; a fourth payload byte is not acknowledged.
- R8: While irq is set, dev_addr and status_word do not change. A clr pulse clears irq, overrun and malformed.
- R9: A correct frame that completes while irq is set sets overrun and leaves dev_addr and status_word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| clr | input | 1 | One-cycle pulse that clears irq, overrun and malformed |
| sda_pull_low | output | 1 | High pulls the data line low (acknowledge) |
| irq | output | 1 | A notification is pending |
| dev_addr | output | 8 | Captured notifying-device byte |
| status_word | output | 16 | Captured status word |
| malformed | output | 1 | Sticky: an accepted frame had the wrong length |
| overrun | output | 1 | Sticky: a notification arrived while irq was set |

## Verification
The assertions assume that SCL holds each level for well over the synchronizer latency of three cycles. They also assume that SDA changes only while SCL is low, except for start and stop, and that clr is a single-cycle pulse. The bench keeps to these assumptions. It holds each SCL phase for ten system clocks, changes SDA only on negative clock edges while SCL is low or at a deliberate start or stop, and drives clr high for exactly one cycle.

// File: rtl/hn_pkg.sv
package hn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ARM,
        ST_ACK_DRIVE,
        ST_DATA,
        ST_OVER,
        ST_SKIP
    } hn_state_t;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/hn_sync.sv
module hn_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prv;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv <= '1;
        else        prv <= lvl;
    end

    assign scl_lvl   = lvl[0];
    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~prv[0];
    assign scl_fall  = ~lvl[0] & prv[0];
    assign start_det = lvl[0] & prv[0] & prv[1] & ~lvl[1];
    assign stop_det  = lvl[0] & prv[0] & ~prv[1] & lvl[1];
endmodule

// File: rtl/hn_frame.sv
module hn_frame
    import hn_pkg::*;
#(
    parameter logic [6:0]  HOST_ADDR = 7'h08,
    parameter int unsigned NBYTES    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_lvl,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    output logic ack_low,
    output logic frame_ok,
    output logic frame_bad,
    output logic [NBYTES-1:0][BYTE_W-1:0] cap_bytes
);
    localparam int unsigned CW = $clog2(NBYTES + 2);
    localparam logic [BYTE_W-1:0] MATCH = {HOST_ADDR, 1'b0};

    hn_state_t state, nxt;
    logic [2:0]        bitcnt;
    logic [CW-1:0]     nbytes;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] byte_in;
    logic              last_bit;
    logic              matched;

    assign byte_in  = {shreg, sda_lvl};
    assign last_bit = scl_rise && (bitcnt == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_OVER, ST_SKIP: nxt = state;
                ST_ADDR:      if (last_bit) nxt = (byte_in == MATCH) ? ST_ACK_ARM : ST_SKIP;
                ST_ACK_ARM:   if (scl_fall) nxt = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) nxt = ST_DATA;
                ST_DATA:      if (last_bit) nxt = (nbytes == CW'(NBYTES)) ? ST_OVER : ST_ACK_ARM;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        matched   = (state == ST_ACK_ARM) || (state == ST_ACK_DRIVE) ||
                    (state == ST_DATA)    || (state == ST_OVER);
        ack_low   = (state == ST_ACK_DRIVE);
        frame_ok  = stop_det && (state == ST_DATA) &&
                    (nbytes == CW'(NBYTES)) && (bitcnt <= 3'd1);
        frame_bad = (stop_det || start_det) && matched && !frame_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            nbytes    <= '0;
            shreg     <= '0;
            cap_bytes <= '0;
        end else if (start_det) begin
            bitcnt <= '0;
            nbytes <= '0;
        end else if (state == ST_ACK_DRIVE && scl_fall) begin
            bitcnt <= '0;
        end else if (scl_rise && (state == ST_ADDR || state == ST_DATA)) begin
            shreg  <= byte_in[BYTE_W-2:0];
            bitcnt <= bitcnt + 3'd1;
            if (state == ST_DATA && bitcnt == 3'd7 && nbytes < CW'(NBYTES)) begin
                for (int i = 0; i < int'(NBYTES); i++) begin
                    if (nbytes == CW'(i)) cap_bytes[i] <= byte_in;
                end
                nbytes <= nbytes + CW'(1);
            end
        end
    end
endmodule

// File: rtl/hn_rx.sv
module hn_rx
    import hn_pkg::*;
#(
    parameter logic [6:0]  HOST_ADDR   = 7'h08,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        clr,
    output logic        sda_pull_low,
    output logic        irq,
    output logic [7:0]  dev_addr,
    output logic [15:0] status_word,
    output logic        malformed,
    output logic        overrun
);
    localparam int unsigned NB = 3;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic frame_ok, frame_bad, pending;
    logic [NB-1:0][BYTE_W-1:0] cap_bytes;

    hn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    hn_frame #(.HOST_ADDR(HOST_ADDR), .NBYTES(NB)) u_frame (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .ack_low(sda_pull_low), .frame_ok(frame_ok), .frame_bad(frame_bad),
        .cap_bytes(cap_bytes)
    );

    assign pending = irq && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq         <= 1'b0;
            overrun     <= 1'b0;
            malformed   <= 1'b0;
            dev_addr    <= '0;
            status_word <= '0;
        end else begin
            if (clr) begin
                irq       <= 1'b0;
                overrun   <= 1'b0;
                malformed <= 1'b0;
            end
            if (frame_ok && !pending) begin
                irq         <= 1'b1;
                dev_addr    <= cap_bytes[0];
                status_word <= {cap_bytes[2], cap_bytes[1]};
            end
            if (frame_ok && pending) overrun <= 1'b1;
            if (frame_bad)           malformed <= 1'b1;
        end
    end
endmodule

// File: rtl/hn_rx_chk.sv
module hn_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic        irq,
    input logic        overrun,
    input logic        malformed,
    input logic [7:0]  dev_addr,
    input logic [15:0] status_word,
    input logic        sda_pull_low,
    input logic        scl_lvl,
    input logic        frame_ok,
    input logic        frame_bad
);
    p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_low) |-> !scl_lvl);

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_ok));

    p_ok_bad_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_bad));

    p_mal_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(malformed) |-> $past(frame_bad));

    p_hold_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq) && !$past(clr)) |-> ($stable(dev_addr) && $stable(status_word)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(frame_ok)) |-> (!irq && !overrun));

    p_overrun_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(frame_ok) && $past(irq)));
endmodule

bind hn_rx hn_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .irq(irq), .overrun(overrun),
    .malformed(malformed), .dev_addr(dev_addr), .status_word(status_word),
    .sda_pull_low(sda_pull_low), .scl_lvl(scl_lvl), .frame_ok(frame_ok),
    .frame_bad(frame_bad)
);

// File: tb/tb_hn_rx.sv
`timescale 1ns/1ps
module tb_hn_rx;
    localparam logic [6:0] HOST = 7'h08;
    localparam int H = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic clr = 1'b0;
    logic sda_pull_low, irq, malformed, overrun;
    logic [7:0]  dev_addr;
    logic [15:0] status_word;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_pull_low;

    hn_rx #(.HOST_ADDR(HOST)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .clr(clr),
        .sda_pull_low(sda_pull_low), .irq(irq), .dev_addr(dev_addr),
        .status_word(status_word), .malformed(malformed), .overrun(overrun)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    logic exp_irq = 0, exp_ovr = 0, exp_mal = 0;
    logic [7:0]  exp_dev = 0;
    logic [15:0] exp_word = 0;
    bit fr_match = 0;
    int fr_cnt = 0;
    logic [7:0] fr_b [4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && rst_n && !done) begin
            check("R6 irq", 32'(irq), 32'(exp_irq));
            check("R5 dev_addr", 32'(dev_addr), 32'(exp_dev));
            check("R5 status_word", 32'(status_word), 32'(exp_word));
            check("R7 malformed", 32'(malformed), 32'(exp_mal));
            check("R9 overrun", 32'(overrun), 32'(exp_ovr));
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_end();
        if (fr_match) begin
            if (fr_cnt == 3) begin
                if (exp_irq) exp_ovr = 1;
                else begin
                    exp_irq  = 1;
                    exp_dev  = fr_b[0];
                    exp_word = {fr_b[2], fr_b[1]};
                end
            end else begin
                exp_mal = 1;
            end
        end
        fr_match = 0;
    endtask

    task automatic bus_start();
        sda_m = 1; wait_n(H);
        scl_m = 1; wait_n(H);
        chk_en = 0;
        sda_m = 0; wait_n(H);
        model_end();
        chk_en = 1;
        scl_m = 0; wait_n(H);
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_n(H);
        scl_m = 1; wait_n(H);
        chk_en = 0;
        sda_m = 1; wait_n(H);
        model_end();
        chk_en = 1;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_n(H);
            scl_m = 1;    wait_n(H);
            scl_m = 0;
        end
        sda_m = 1; wait_n(H);
        scl_m = 1; wait_n(H / 2);
        check(req, 32'(sda_pull_low), 32'(exp_ack));
        check({req, " bus"}, 32'(sda_bus), 32'(!exp_ack));
        wait_n(H / 2);
        scl_m = 0;
    endtask

    task automatic frame(input logic [7:0] a, input int n,
                         input logic [7:0] p0, input logic [7:0] p1,
                         input logic [7:0] p2, input logic [7:0] p3,
                         input bit end_stop);
        logic [7:0] p [4];
        bit am;
        p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
        bus_start();
        am = (a == {HOST, 1'b0});
        send_byte(a, am, am ? "R2 address ack" : "R3 address no ack");
        fr_match = am;
        fr_cnt = 0;
        for (int i = 0; i < n; i++) begin
            if (!am)        send_byte(p[i], 1'b0, "R3 payload ignored");
            else if (i < 3) send_byte(p[i], 1'b1, "R4 payload ack");
            else            send_byte(p[i], 1'b0, "R7 extra byte no ack");
            if (am) begin
                if (i < 4) fr_b[i] = p[i];
                fr_cnt++;
            end
        end
        if (end_stop) bus_stop();
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        chk_en = 0;
        clr = 1;
        @(negedge clk);
        clr = 0;
        exp_irq = 0; exp_ovr = 0; exp_mal = 0;
        chk_en = 1;
    endtask

    initial begin
        wait_n(5);
        check("R8 reset irq", 32'(irq), 32'd0);
        check("R8 reset flags", 32'({malformed, overrun}), 32'd0);
        check("R2 reset ack", 32'(sda_pull_low), 32'd0);
        rst_n = 1;
        wait_n(4);
        chk_en = 1;

        // R1: SDA toggles while SCL is low must not frame anything
        scl_m = 0; wait_n(H);
        sda_m = 0; wait_n(H);
        sda_m = 1; wait_n(H);
        sda_m = 0; wait_n(H);
        sda_m = 1; wait_n(H);
        scl_m = 1; wait_n(H);
        check("R1 no spurious frame", 32'({irq, malformed}), 32'd0);

        // R5 R6: valid notify
        frame({HOST, 1'b0}, 3, 8'h5A, 8'h34, 8'h12, 8'h00, 1);
        check("R6 irq after good frame", 32'(irq), 32'd1);
        check("R5 word", 32'(status_word), 32'h1234);

        // R9: second notify while pending
        frame({HOST, 1'b0}, 3, 8'hC3, 8'hEF, 8'hBE, 8'h00, 1);
        check("R9 overrun set", 32'(overrun), 32'd1);
        check("R9 dev held", 32'(dev_addr), 32'h5A);

        pulse_clr();
        check("R8 cleared", 32'({irq, overrun, malformed}), 32'd0);

        // R3: other address, and read bit
        frame({7'h22, 1'b0}, 3, 8'h11, 8'h22, 8'h33, 8'h00, 1);
        frame({HOST, 1'b1}, 3, 8'h44, 8'h55, 8'h66, 8'h00, 1);
        check("R3 nothing raised", 32'({irq, overrun, malformed}), 32'd0);

        // R7: short frame
        frame({HOST, 1'b0}, 2, 8'h01, 8'h02, 8'h00, 8'h00, 1);
        check("R7 short malformed", 32'({irq, malformed}), 32'b01);
        pulse_clr();

        // R7: long frame
        frame({HOST, 1'b0}, 4, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 1);
        check("R7 long malformed", 32'({irq, malformed}), 32'b01);
        pulse_clr();

        // R7: repeated start cuts a frame, then a good frame follows
        frame({HOST, 1'b0}, 1, 8'h77, 8'h00, 8'h00, 8'h00, 0);
        frame({HOST, 1'b0}, 3, 8'h81, 8'h00, 8'hFF, 8'h00, 1);
        check("R7 restart malformed", 32'(malformed), 32'd1);
        check("R5 word after restart", 32'(status_word), 32'hFF00);
        pulse_clr();

        // R8: after clear, a new notify loads fresh values
        frame({HOST, 1'b0}, 3, 8'hFF, 8'hA5, 8'h5A, 8'h00, 1);
        check("R8 reload dev", 32'(dev_addr), 32'hFF);
        check("R5 reload word", 32'(status_word), 32'h5AA5);
        pulse_clr();
        wait_n(20);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule